// File: doc/BRIEF.md
# Integer Add and Subtract-From Unit with Condition Flags

This block is the add/subtract slice of a 32-bit RISC execute stage. Each clock it takes two operands, an operation select and a set of modifier bits, together with the architectural carry, overflow and summary-overflow bits as they stand. It returns the result, the updated state bits and a four-bit condition field. All outputs are registered, so they appear one clock after the inputs.

Two operations exist: add (A + B) and subtract-from (B minus A). The second operand can be the register value, a constant zero, a constant all-ones, or a 16-bit immediate placed in the upper half. The extended modifier replaces the fixed carry-in with the incoming carry bit. Subtraction keeps carry as "no borrow". The summary-overflow bit is sticky. The condition field is always computed, and a write-enable flag says whether the instruction asked to record it.

Top module: `addsub_unit`

## Requirements
- R1: With op_i = 0 (add), res_o = A + B' + (ext_i ? ca_i : 0), modulo 2^32, where B' is the selected second operand.
- R2: With op_i = 1 (subtract-from), res_o = B' + ~A + (ext_i ? ca_i : 1), modulo 2^32; without ext_i this is B' − A.
- R3: bsrc_i selects B': 0 = b_i, 1 = 0x00000000, 2 = 0xFFFFFFFF, 3 = {b_i[15:0], 16'h0000}.
- R4: When ca_upd_i or ext_i is set, ca_o is the carry out of bit 31 of the sum in R1 or R2. For subtract-from, 1 therefore means no borrow.
- R5: When neither ca_upd_i nor ext_i is set, ca_o equals ca_i.
- R6: When oe_i is set, ov_o is 1 exactly when the true signed result falls outside the 32-bit signed range. For add, that is: both operands have the same sign and the result sign differs. For subtract-from, that is: the signs of A and B' differ and the result sign differs from B'.
- R7: When oe_i is set, so_o = so_i | ov_o. When oe_i is clear, ov_o = ov_i and so_o = so_i. so_o is therefore never lower than so_i.
- R8: cr_o is {LT, GT, EQ, SO}, with LT in bit 3 and SO in bit 0. LT = res_o[31]. GT = result nonzero and res_o[31] = 0. EQ = result zero. SO = so_o.
- R9: cr_wr_o equals rec_i from the same operation.
- R10: Every output shows the operation applied one clock edge earlier. While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 1 | 0 = add, 1 = subtract-from |
| bsrc_i | input | 2 | Second-operand source select (see R3) |
| rec_i | input | 1 | Record the condition field |
| ca_upd_i | input | 1 | Carry modifier: update the carry bit |
| ext_i | input | 1 | Extended modifier: carry-in is ca_i |
| oe_i | input | 1 | Overflow-enable modifier |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B or immediate (low 16 bits) |
| ca_i | input | 1 | Current carry bit |
| ov_i | input | 1 | Current overflow bit |
| so_i | input | 1 | Current summary-overflow bit |
| res_o | output | 32 | Result |
| ca_o | output | 1 | Next carry bit |
| ov_o | output | 1 | Next overflow bit |
| so_o | output | 1 | Next summary-overflow bit |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr_wr_o | output | 1 | Condition field write enable |

## Verification
The unit keeps no state between operations apart from its output register. A wrong carry-in choice, operand inversion or operand source therefore shows on res_o and ca_o at the clock right after that operation, and is gone by the next. A wrong overflow term shows on ov_o, so_o and the SO bit of cr_o in that same cycle. The corners that expose such faults are the sign boundaries 0x7FFFFFFF and 0x80000000, equal operands in subtraction, and carry-in with an all-ones operand. The reference model derives every expected value from wide signed and unsigned arithmetic rather than from bit-level adder terms.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;

    typedef enum logic {
        OP_ADD  = 1'b0,
        OP_SUBF = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        BSRC_REG  = 2'd0,
        BSRC_ZERO = 2'd1,
        BSRC_ONES = 2'd2,
        BSRC_HIGH = 2'd3
    } bsrc_e;

    // condition field, LT in the top bit
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_t;

endpackage

// File: rtl/addsub_bsel.sv
`timescale 1ns/1ps
module addsub_bsel
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  bsrc_e              bsrc_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [WIDTH-1:0]   b_o
);
    localparam int LOW_W = WIDTH - IMM_W;

    logic [WIDTH-1:0] high_imm;

    // immediate moved into the upper part of the word
    assign high_imm = {b_i[IMM_W-1:0], {LOW_W{1'b0}}};

    always_comb begin
        unique case (bsrc_i)
            BSRC_REG:  b_o = b_i;
            BSRC_ZERO: b_o = '0;
            BSRC_ONES: b_o = '1;
            BSRC_HIGH: b_o = high_imm;
            default:   b_o = b_i;
        endcase
    end
endmodule

// File: rtl/addsub_core.sv
`timescale 1ns/1ps
module addsub_core #(
    parameter int WIDTH = 32
) (
    input  logic               sub_i,
    input  logic               ext_i,
    input  logic               ca_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [WIDTH-1:0]   sum_o,
    output logic               cout_o,
    output logic               ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] x_op;
    logic             cin;
    logic [WIDTH:0]   wide;

    // subtract-from is B + ~A + 1; extended forms take carry-in from state
    assign x_op = sub_i ? ~a_i : a_i;
    assign cin  = ext_i ? ca_i : sub_i;
    assign wide = {1'b0, x_op} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin};

    assign sum_o  = wide[WIDTH-1:0];
    assign cout_o = wide[WIDTH];
    // adder inputs of equal sign giving a result of the other sign
    assign ovf_o  = (x_op[MSB] ~^ b_i[MSB]) & (wide[MSB] ^ x_op[MSB]);
endmodule

// File: rtl/addsub_crf.sv
`timescale 1ns/1ps
module addsub_crf
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   res_i,
    input  logic               so_i,
    output crf_t               crf_o
);
    logic nz;

    assign nz = |res_i;

    always_comb begin
        crf_o.lt = res_i[WIDTH-1];
        crf_o.gt = nz & ~res_i[WIDTH-1];
        crf_o.eq = ~nz;
        crf_o.so = so_i;
    end
endmodule

// File: rtl/addsub_unit.sv
`timescale 1ns/1ps
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               op_i,
    input  logic [1:0]         bsrc_i,
    input  logic               rec_i,
    input  logic               ca_upd_i,
    input  logic               ext_i,
    input  logic               oe_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic               ca_i,
    input  logic               ov_i,
    input  logic               so_i,
    output logic [WIDTH-1:0]   res_o,
    output logic               ca_o,
    output logic               ov_o,
    output logic               so_o,
    output logic [3:0]         cr_o,
    output logic               cr_wr_o
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             ca;
        logic             ov;
        logic             so;
        crf_t             cr;
        logic             cr_wr;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [WIDTH-1:0] b_sel;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             ovf;
    logic             so_next;
    crf_t             crf;

    addsub_bsel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_bsel (
        .bsrc_i (bsrc_e'(bsrc_i)),
        .b_i    (b_i),
        .b_o    (b_sel)
    );

    addsub_core #(.WIDTH(WIDTH)) u_core (
        .sub_i  (op_i == OP_SUBF),
        .ext_i  (ext_i),
        .ca_i   (ca_i),
        .a_i    (a_i),
        .b_i    (b_sel),
        .sum_o  (sum),
        .cout_o (cout),
        .ovf_o  (ovf)
    );

    // sticky summary overflow feeds the recorded field
    assign so_next = oe_i ? (so_i | ovf) : so_i;

    addsub_crf #(.WIDTH(WIDTH)) u_crf (
        .res_i  (sum),
        .so_i   (so_next),
        .crf_o  (crf)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.res   = sum;
        stage_d.ca    = (ca_upd_i | ext_i) ? cout : ca_i;
        stage_d.ov    = oe_i ? ovf : ov_i;
        stage_d.so    = so_next;
        stage_d.cr    = crf;
        stage_d.cr_wr = rec_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign res_o   = stage_q.res;
    assign ca_o    = stage_q.ca;
    assign ov_o    = stage_q.ov;
    assign so_o    = stage_q.so;
    assign cr_o    = stage_q.cr;
    assign cr_wr_o = stage_q.cr_wr;

    // R5
    carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ca_upd_i && !ext_i) |=> (ca_o == $past(ca_i)));

    // R7
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_i |=> ((ov_o == $past(ov_i)) && (so_o == $past(so_i))));

    // R7
    so_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        so_i |=> so_o);

    // R9
    record_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (cr_wr_o == $past(rec_i)));

    // R8
    eq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cr_wr_o |-> (cr_o[1] == (res_o == '0)));

    // R8
    sign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cr_wr_o |-> ((cr_o[3] == res_o[WIDTH-1]) && ($countones(cr_o[3:1]) == 1)));

    // R8
    so_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cr_wr_o |-> (cr_o[0] == so_o));
endmodule

// File: tb/test_addsub_unit.sv
`timescale 1ns/1ps
module test_addsub_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op = 0, rec = 0, cu = 0, ext = 0, oe = 0;
    logic [1:0]  bsrc = 0;
    logic [31:0] a = 0, b = 0;
    logic        ca = 0, ov = 0, so = 0;
    logic [31:0] res;
    logic        ca_o, ov_o, so_o, cr_wr;
    logic [3:0]  cr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    addsub_unit i_addsub_unit (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .bsrc_i(bsrc), .rec_i(rec),
        .ca_upd_i(cu), .ext_i(ext), .oe_i(oe), .a_i(a), .b_i(b),
        .ca_i(ca), .ov_i(ov), .so_i(so),
        .res_o(res), .ca_o(ca_o), .ov_o(ov_o), .so_o(so_o),
        .cr_o(cr), .cr_wr_o(cr_wr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference using wide integer arithmetic
    task automatic run(input logic o, input logic [1:0] bs, input logic r,
                       input logic c_u, input logic e, input logic oen,
                       input logic [31:0] av, input logic [31:0] bv,
                       input logic cav, input logic ovv, input logic sov);
        logic [31:0] bp, e_res;
        longint      u, s;
        logic        cin, e_ca, e_ov, e_so, ovf;
        logic [3:0]  e_cr;
        string       rtag;
        @(negedge clk);
        op = o; bsrc = bs; rec = r; cu = c_u; ext = e; oe = oen;
        a = av; b = bv; ca = cav; ov = ovv; so = sov;
        case (bs)
            2'd0: bp = bv;
            2'd1: bp = 32'h0;
            2'd2: bp = 32'hFFFF_FFFF;
            default: bp = {bv[15:0], 16'h0};
        endcase
        if (!o) begin
            cin = e ? cav : 1'b0;
            u = longint'(av) + longint'(bp) + longint'(cin);
            s = longint'($signed(av)) + longint'($signed(bp)) + longint'(cin);
            e_res = u[31:0];
            e_ca  = u[32];
        end else begin
            cin = e ? cav : 1'b1;
            u = longint'(bp) - longint'(av) - 1 + longint'(cin);
            s = longint'($signed(bp)) - longint'($signed(av)) - 1 + longint'(cin);
            e_res = u[31:0];
            e_ca  = (u >= 0);
        end
        ovf  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        e_ca = (c_u | e) ? e_ca : cav;
        e_ov = oen ? ovf : ovv;
        e_so = oen ? (sov | ovf) : sov;
        e_cr = {e_res[31], (e_res != 0) && !e_res[31], e_res == 0, e_so};
        @(posedge clk);
        @(negedge clk);
        rtag = o ? "R2" : "R1";
        if (bs != 2'd0) rtag = {rtag, " R3"};
        chk({rtag, " R10 result"}, res, e_res);
        chk((c_u | e) ? "R4 carry" : "R5 carry", {31'b0, ca_o}, {31'b0, e_ca});
        chk(oen ? "R6 overflow" : "R7 overflow hold", {31'b0, ov_o}, {31'b0, e_ov});
        chk("R7 summary overflow", {31'b0, so_o}, {31'b0, e_so});
        chk("R8 condition field", {28'b0, cr}, {28'b0, e_cr});
        chk("R9 record flag", {31'b0, cr_wr}, {31'b0, r});
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 reset result", res, 32'h0);
        chk("R10 reset flags", {27'b0, ca_o, ov_o, so_o, cr_wr, |cr}, 32'h0);
        rst_n = 1'b1;

        // R1 R6 add overflow at the positive boundary
        run(0, 0, 1, 1, 0, 1, 32'h7FFF_FFFF, 32'h1, 0, 0, 0);
        // R1 R4 carry-in through all ones, result zero
        run(0, 0, 1, 0, 1, 1, 32'hFFFF_FFFF, 32'h0, 1, 0, 0);
        // R2 R4 equal operands: no borrow, EQ set
        run(1, 0, 1, 1, 0, 1, 32'h5, 32'h5, 0, 0, 0);
        // R2 R4 borrow: 0 - 1
        run(1, 0, 1, 1, 0, 0, 32'h1, 32'h0, 1, 0, 0);
        // R6 subtract overflow: 0x7FFFFFFF - (-1)
        run(1, 0, 1, 0, 0, 1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0);
        // R6 subtract: signs differ without overflow
        run(1, 0, 1, 0, 0, 1, 32'h1, 32'h8000_0001, 0, 0, 0);
        // R3 zero form extended
        run(0, 1, 1, 0, 1, 0, 32'h1234_5678, 32'hDEAD_BEEF, 1, 0, 0);
        // R3 minus-one form subtract extended
        run(1, 2, 1, 0, 1, 1, 32'h0, 32'h0, 0, 0, 0);
        // R3 shifted immediate
        run(0, 3, 1, 0, 0, 0, 32'h0000_0010, 32'hABCD_8001, 0, 0, 0);
        // R5 carry held when no carry modifier
        run(0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 1);
        // R7 sticky summary with overflow enable and no new overflow
        run(0, 0, 1, 0, 0, 1, 32'h1, 32'h2, 0, 1, 1);
        // R9 record off
        run(1, 0, 0, 1, 0, 0, 32'h8000_0000, 32'h0, 1, 0, 0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if ($urandom_range(0, 3) == 0) ra = ($urandom_range(0, 1) != 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
            if ($urandom_range(0, 3) == 0) rb = ($urandom_range(0, 1) != 0) ? ra : ~ra;
            run(1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), ra, rb,
                1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule